// File: doc/BRIEF.md
# Regional CRC Frozen Frame Detector

This block watches a raster pixel stream and checks whether any part of the picture has stopped changing. Each of up to nine rectangular regions, placed by a configuration table of origin and size, keeps its own CRC over the pixels that fall inside it. At every end-of-frame strobe the finished CRC of each region is published and compared with the value that region produced one frame earlier.

A per-region counter tracks how many frames in a row have repeated. When any active region's counter reaches the programmable threshold, a sticky error flag rises. A mask shows which regions caused it. A single stuck region is enough, even while every other region keeps changing. Software clears the flag with a write-one-to-clear strobe. Dropping the enable input silences the detector and discards all history.

Top module: `rgn_freeze_det`

## Requirements
- R1: A pixel with coordinates (x, y) belongs to region i when x0 <= x < x0+width and y0 <= y < y0+height, compared without wrap-around. Regions may overlap, and a valid pixel updates every region that contains it.
- R2: Each region's CRC is CRC-32 with polynomial 0x04C11DB7, shifted MSB first, with no reflection and no final inversion. Each 24-bit pixel is fed bit 23 first. The CRC is seeded with 0xFFFFFFFF at reset and after every end-of-frame. Region i's finished CRC appears on crc_out[32i+31:32i] in the cycle after frame_end, and it reads 0xFFFFFFFF after reset.
- R3: rgn_count selects how many regions are tracked, namely regions 0 to count-1. A value of 0 acts as 1 and a value above 9 acts as 9. An inactive region never counts a repeat and never sets a mask bit.
- R4: The first end-of-frame after reset, after enable rises, or after a region becomes active only stores a reference CRC. It never counts as a repeat.
- R5: At each end-of-frame, an active region's counter grows by one when its CRC equals its previous CRC, and returns to zero when the CRC differs. The counter saturates at the threshold. The error is raised when the counter reaches the threshold, and a threshold of 0 acts as 1.
- R6: Any single active region reaching the threshold sets frozen_err and its own bit i of stuck_mask in the cycle after frame_end, whatever the other regions do.
- R7: frozen_err and stuck_mask stay set until err_clear is high for a cycle. If a new detection happens in the same cycle as err_clear, the detection wins and the flag stays set.
- R8: While enable is low, frozen_err and stuck_mask are held at zero and all repeat history is discarded.
- R9: A pixel presented with pix_valid in the same cycle as frame_end is included in the frame that ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Detector enable |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 24 | RGB pixel value |
| pix_x | input | CW (12) | Pixel column |
| pix_y | input | CW (12) | Pixel row |
| frame_end | input | 1 | One-cycle strobe closing the current frame |
| rgn_count | input | 4 | Number of tracked regions |
| rgn_x0 | input | N_RGN*CW | Packed region x origins, region i at [CW*i +: CW] |
| rgn_y0 | input | N_RGN*CW | Packed region y origins |
| rgn_w | input | N_RGN*CW | Packed region widths |
| rgn_h | input | N_RGN*CW | Packed region heights |
| threshold | input | THR_W (4) | Repeat count that declares a frozen frame |
| err_clear | input | 1 | Write-one-to-clear for the error and mask |
| frozen_err | output | 1 | Sticky frozen-frame error |
| stuck_mask | output | N_RGN (9) | Regions that triggered the error |
| crc_out | output | N_RGN*32 | Latest finished CRC per region |

## Verification
Two events can land in the same clock. The first is a region completing its run of repeats while err_clear is high, which the bench provokes by raising err_clear in the very frame_end cycle of a frame that should trip the threshold. The bench then checks that the flag and the mask bit are still set afterwards. The second is the last pixel of a frame arriving in the frame_end cycle, which is exercised in alternate frames. A one-pixel region sitting on that last pixel shows whether the pixel was folded into the published CRC.

// File: rtl/rgn_freeze_pkg.sv
package rgn_freeze_pkg;

    localparam int PIX_W = 24;
    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    // Folds one pixel into a running CRC, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                  input logic [PIX_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int b = PIX_W - 1; b >= 0; b--) begin
            fb = r[CRC_W-1] ^ d[b];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    typedef struct packed {
        logic [CRC_W-1:0] acc;
        logic [CRC_W-1:0] hold;
    } lane_st_t;

endpackage

// File: rtl/rgn_crc_lane.sv
module rgn_crc_lane
    import rgn_freeze_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [CW-1:0]    pix_x,
    input  logic [CW-1:0]    pix_y,
    input  logic             frame_end,
    input  logic [CW-1:0]    x0,
    input  logic [CW-1:0]    y0,
    input  logic [CW-1:0]    w,
    input  logic [CW-1:0]    h,
    output logic [CRC_W-1:0] frame_crc,
    output logic [CRC_W-1:0] crc_q
);

    lane_st_t lane_d, lane_q;
    logic [CRC_W-1:0] folded;
    logic in_x, in_y, hit;

    always_comb begin
        in_x   = ({1'b0, pix_x} >= {1'b0, x0}) &&
                 ({1'b0, pix_x} < ({1'b0, x0} + {1'b0, w}));
        in_y   = ({1'b0, pix_y} >= {1'b0, y0}) &&
                 ({1'b0, pix_y} < ({1'b0, y0} + {1'b0, h}));
        hit    = pix_valid && in_x && in_y;
        folded = hit ? crc_fold(lane_q.acc, pix_data) : lane_q.acc;
        lane_d = lane_q;
        if (frame_end) begin
            lane_d.acc  = CRC_SEED;
            lane_d.hold = folded;
        end else begin
            lane_d.acc  = folded;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '{acc: CRC_SEED, hold: CRC_SEED};
        else        lane_q <= lane_d;
    end

    assign frame_crc = folded;
    assign crc_q     = lane_q.hold;

    // R1
    acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_valid && !frame_end) |=> $stable(lane_q.acc));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(crc_q));

endmodule

// File: rtl/rgn_repeat_track.sv
module rgn_repeat_track
    import rgn_freeze_pkg::*;
#(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             active,
    input  logic             frame_end,
    input  logic [CRC_W-1:0] frame_crc,
    input  logic [THR_W-1:0] thr_eff,
    output logic             stuck_set
);

    typedef struct packed {
        logic [CRC_W-1:0] prev;
        logic [THR_W-1:0] cnt;
        logic             ref_ok;
    } trk_t;

    trk_t trk_d, trk_q;
    logic same;

    always_comb begin
        trk_d     = trk_q;
        same      = (frame_crc == trk_q.prev);
        stuck_set = 1'b0;
        if (!enable || !active) begin
            trk_d.cnt    = '0;
            trk_d.ref_ok = 1'b0;
        end else if (frame_end) begin
            trk_d.prev   = frame_crc;
            trk_d.ref_ok = 1'b1;
            if (trk_q.ref_ok && same) begin
                trk_d.cnt = (trk_q.cnt >= thr_eff) ? thr_eff : trk_q.cnt + 1'b1;
                stuck_set = (trk_d.cnt >= thr_eff);
            end else begin
                trk_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '{prev: '0, cnt: '0, ref_ok: 1'b0};
        else        trk_q <= trk_d;
    end

    // R4
    ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && active && frame_end && !trk_q.ref_ok) |=> (trk_q.cnt == '0));

    // R5
    miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && active && frame_end && (frame_crc != trk_q.prev)) |=> (trk_q.cnt == '0));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.cnt > $past(trk_q.cnt)) |-> (trk_q.cnt == $past(trk_q.cnt) + 1'b1));

    // R6
    set_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_set |-> (frame_end && enable && active));

endmodule

// File: rtl/rgn_freeze_det.sv
module rgn_freeze_det
    import rgn_freeze_pkg::*;
#(
    parameter  int N_RGN  = 9,
    parameter  int CW     = 12,
    parameter  int THR_W  = 4,
    localparam int RCNT_W = $clog2(N_RGN + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   pix_valid,
    input  logic [PIX_W-1:0]       pix_data,
    input  logic [CW-1:0]          pix_x,
    input  logic [CW-1:0]          pix_y,
    input  logic                   frame_end,
    input  logic [RCNT_W-1:0]      rgn_count,
    input  logic [N_RGN*CW-1:0]    rgn_x0,
    input  logic [N_RGN*CW-1:0]    rgn_y0,
    input  logic [N_RGN*CW-1:0]    rgn_w,
    input  logic [N_RGN*CW-1:0]    rgn_h,
    input  logic [THR_W-1:0]       threshold,
    input  logic                   err_clear,
    output logic                   frozen_err,
    output logic [N_RGN-1:0]       stuck_mask,
    output logic [N_RGN*CRC_W-1:0] crc_out
);

    typedef struct packed {
        logic             flag;
        logic [N_RGN-1:0] mask;
    } err_t;

    err_t err_d, err_q;
    logic [RCNT_W-1:0] cnt_eff;
    logic [THR_W-1:0]  thr_eff;
    logic [N_RGN-1:0]  active;
    logic [N_RGN-1:0]  set_vec;

    always_comb begin
        if (rgn_count == '0)                      cnt_eff = RCNT_W'(1);
        else if (rgn_count > RCNT_W'(N_RGN))      cnt_eff = RCNT_W'(N_RGN);
        else                                      cnt_eff = rgn_count;
        thr_eff = (threshold == '0) ? THR_W'(1) : threshold;
    end

    for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
        logic [CRC_W-1:0] fcrc;

        assign active[g] = (RCNT_W'(g) < cnt_eff);

        rgn_crc_lane #(.CW(CW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .pix_valid (pix_valid),
            .pix_data  (pix_data),
            .pix_x     (pix_x),
            .pix_y     (pix_y),
            .frame_end (frame_end),
            .x0        (rgn_x0[g*CW +: CW]),
            .y0        (rgn_y0[g*CW +: CW]),
            .w         (rgn_w[g*CW +: CW]),
            .h         (rgn_h[g*CW +: CW]),
            .frame_crc (fcrc),
            .crc_q     (crc_out[g*CRC_W +: CRC_W])
        );

        rgn_repeat_track #(.THR_W(THR_W)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (enable),
            .active    (active[g]),
            .frame_end (frame_end),
            .frame_crc (fcrc),
            .thr_eff   (thr_eff),
            .stuck_set (set_vec[g])
        );
    end

    always_comb begin
        err_d = err_q;
        if (!enable) begin
            err_d = '0;
        end else begin
            if (err_clear) err_d = '0;
            err_d.mask = err_d.mask | set_vec;
            if (|set_vec) err_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign frozen_err = err_q.flag;
    assign stuck_mask = err_q.mask;

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!frozen_err && stuck_mask == '0));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_err && enable && !err_clear) |=> frozen_err);

    // R6
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen_err) |-> $past(frame_end));

    // R6
    mask_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_mask != '0) |-> frozen_err);

    // R3
    set_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & ~active) == '0));

endmodule

// File: tb/rgn_freeze_det_bench.sv
module rgn_freeze_det_bench;

    localparam int N  = 9;
    localparam int CW = 12;
    localparam int TW = 4;
    localparam int RW = 4;
    localparam int FW = 8;
    localparam int FH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic [CW-1:0] pix_x = '0;
    logic [CW-1:0] pix_y = '0;
    logic frame_end = 1'b0;
    logic [RW-1:0] rgn_count = '0;
    logic [N*CW-1:0] rgn_x0, rgn_y0, rgn_w, rgn_h;
    logic [TW-1:0] threshold = '0;
    logic err_clear = 1'b0;
    logic frozen_err;
    logic [N-1:0] stuck_mask;
    logic [N*32-1:0] crc_out;

    always #5 clk = ~clk;

    rgn_freeze_det u_rgn_freeze_det (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_x(pix_x), .pix_y(pix_y), .frame_end(frame_end),
        .rgn_count(rgn_count), .rgn_x0(rgn_x0), .rgn_y0(rgn_y0), .rgn_w(rgn_w),
        .rgn_h(rgn_h), .threshold(threshold), .err_clear(err_clear),
        .frozen_err(frozen_err), .stuck_mask(stuck_mask), .crc_out(crc_out)
    );

    int rx[N] = '{0, 2, 4, 0, 7, 0, 6, 1, 3};
    int ry[N] = '{0, 1, 0, 3, 5, 0, 2, 4, 0};
    int rw[N] = '{4, 4, 4, 8, 1, 8, 5, 2, 1};
    int rh[N] = '{3, 3, 3, 3, 1, 6, 5, 2, 6};

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_prev[N];
    logic [31:0] m_crc[N];
    int m_cnt[N];
    bit m_ref[N];
    bit m_err;
    logic [N-1:0] m_mask;
    bit m_en;
    int m_rc;
    int m_th;

    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [23:0] d);
        for (int k = 0; k < 24; k++) begin
            logic t;
            t = c[31] ^ d[23-k];
            c = {c[30:0], 1'b0} ^ ({32{t}} & 32'h04C11DB7);
        end
        return c;
    endfunction

    function automatic logic [23:0] pix_fn(int seed, bit lock, int x, int y);
        if (lock && x < 4 && y < 3) return 24'hA5C3F0;
        return 24'(seed * 127813 + x * 2353 + y * 1969 + x * y * 77 + 5);
    endfunction

    function automatic int eff_cnt();
        if (m_rc == 0) return 1;
        if (m_rc > N) return N;
        return m_rc;
    endfunction

    function automatic int eff_thr();
        return (m_th == 0) ? 1 : m_th;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_clear_history();
        for (int i = 0; i < N; i++) begin
            m_ref[i] = 0;
            m_cnt[i] = 0;
        end
        m_err  = 0;
        m_mask = '0;
    endtask

    task automatic set_enable(bit v);
        @(negedge clk);
        enable = v;
        m_en = v;
        if (!v) model_clear_history();
        @(negedge clk);
        if (!v) begin
            check(frozen_err == 1'b0, "R8", "error while disabled", 64'(frozen_err), 64'(0));
            check(stuck_mask == '0, "R8", "mask while disabled", 64'(stuck_mask), 64'(0));
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        m_err = 0;
        m_mask = '0;
        check(frozen_err == 1'b0, "R7", "error after clear", 64'(frozen_err), 64'(0));
        check(stuck_mask == '0, "R7", "mask after clear", 64'(stuck_mask), 64'(0));
    endtask

    task automatic run_frame(int seed, bit lock, bit tail, bit clr);
        for (int y = 0; y < FH; y++) begin
            for (int x = 0; x < FW; x++) begin
                @(negedge clk);
                pix_valid = 1'b1;
                pix_x     = CW'(x);
                pix_y     = CW'(y);
                pix_data  = pix_fn(seed, lock, x, y);
                if (tail && x == FW - 1 && y == FH - 1) begin
                    frame_end = 1'b1;
                    err_clear = clr;
                end
            end
        end
        if (!tail) begin
            @(negedge clk);
            pix_valid = 1'b0;
            frame_end = 1'b1;
            err_clear = clr;
        end
        @(negedge clk);
        pix_valid = 1'b0;
        frame_end = 1'b0;
        err_clear = 1'b0;
        // expected values from the requirements
        for (int i = 0; i < N; i++) begin
            logic [31:0] c;
            c = 32'hFFFFFFFF;
            for (int y = 0; y < FH; y++)
                for (int x = 0; x < FW; x++)
                    if (x >= rx[i] && x < rx[i] + rw[i] && y >= ry[i] && y < ry[i] + rh[i])
                        c = ref_crc(c, pix_fn(seed, lock, x, y));
            m_crc[i] = c;
        end
        if (clr) begin
            m_err = 0;
            m_mask = '0;
        end
        if (m_en) begin
            for (int i = 0; i < N; i++) begin
                if (i < eff_cnt()) begin
                    if (m_ref[i] && m_crc[i] == m_prev[i]) begin
                        m_cnt[i] = (m_cnt[i] + 1 > eff_thr()) ? eff_thr() : m_cnt[i] + 1;
                        if (m_cnt[i] >= eff_thr()) begin
                            m_mask[i] = 1'b1;
                            m_err = 1;
                        end
                    end else begin
                        m_cnt[i] = 0;
                    end
                    m_prev[i] = m_crc[i];
                    m_ref[i] = 1;
                end else begin
                    m_ref[i] = 0;
                    m_cnt[i] = 0;
                end
            end
        end
        for (int i = 0; i < N; i++)
            check(crc_out[i*32 +: 32] == m_crc[i], tail ? "R9" : "R1",
                  $sformatf("region %0d crc", i), 64'(crc_out[i*32 +: 32]), 64'(m_crc[i]));
        check(frozen_err == m_err, "R6", "frozen error", 64'(frozen_err), 64'(m_err));
        check(stuck_mask == m_mask, "R6", "stuck mask", 64'(stuck_mask), 64'(m_mask));
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            rgn_x0[i*CW +: CW] = CW'(rx[i]);
            rgn_y0[i*CW +: CW] = CW'(ry[i]);
            rgn_w[i*CW +: CW]  = CW'(rw[i]);
            rgn_h[i*CW +: CW]  = CW'(rh[i]);
        end
        m_en = 0;
        model_clear_history();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(frozen_err == 1'b0, "R2", "reset error", 64'(frozen_err), 64'(0));
        check(stuck_mask == '0, "R2", "reset mask", 64'(stuck_mask), 64'(0));
        for (int i = 0; i < N; i++)
            check(crc_out[i*32 +: 32] == 32'hFFFFFFFF, "R2", "reset crc",
                  64'(crc_out[i*32 +: 32]), 64'(32'hFFFFFFFF));

        // static corner under region 0, rest changing
        rgn_count = RW'(9); m_rc = 9;
        threshold = TW'(3); m_th = 3;
        set_enable(1);
        for (int f = 1; f <= 5; f++) run_frame(f, 1, f[0], 0);
        check(stuck_mask == 9'h001, "R6", "only region 0 stuck", 64'(stuck_mask), 64'(1));

        // clear, then saturated counter trips again next frame
        pulse_clear();
        run_frame(6, 1, 0, 0);
        check(frozen_err == 1'b1, "R5", "saturated count re-trips", 64'(frozen_err), 64'(1));

        // clear in the same cycle as a new detection
        run_frame(7, 1, 1, 1);
        check(frozen_err == 1'b1, "R7", "detection beats clear", 64'(frozen_err), 64'(1));

        // disabled: frames never raise the error
        set_enable(0);
        run_frame(8, 1, 0, 0);
        run_frame(9, 1, 0, 0);
        check(frozen_err == 1'b0, "R8", "no error while disabled", 64'(frozen_err), 64'(0));

        // re-enable: first frame is only a reference
        threshold = TW'(2); m_th = 2;
        set_enable(1);
        run_frame(10, 1, 0, 0);
        check(frozen_err == 1'b0, "R4", "reference frame after enable", 64'(frozen_err), 64'(0));
        run_frame(11, 1, 1, 0);
        run_frame(12, 1, 0, 0);

        // a changed CRC restarts the run
        set_enable(0);
        threshold = TW'(4); m_th = 4;
        set_enable(1);
        run_frame(5, 0, 0, 0);
        run_frame(5, 0, 1, 0);
        run_frame(6, 0, 0, 0);
        run_frame(6, 0, 0, 0);
        run_frame(6, 0, 1, 0);
        run_frame(6, 0, 0, 0);
        check(frozen_err == 1'b0, "R5", "run restarted by change", 64'(frozen_err), 64'(0));
        run_frame(6, 0, 0, 0);
        check(frozen_err == 1'b1, "R5", "fourth repeat trips", 64'(frozen_err), 64'(1));

        // region count sweep, everything frozen, threshold 1
        for (int c = 0; c <= 11; c++) begin
            int e;
            set_enable(0);
            rgn_count = RW'(c); m_rc = c;
            threshold = TW'(1); m_th = 1;
            set_enable(1);
            run_frame(20, 0, c[0], 0);
            run_frame(20, 0, c[0], 0);
            e = eff_cnt();
            check(stuck_mask == N'((1 << e) - 1), "R3", $sformatf("mask for count %0d", c),
                  64'(stuck_mask), 64'((1 << e) - 1));
        end

        // threshold sweep including 0
        rgn_count = RW'(9); m_rc = 9;
        for (int t = 0; t <= 5; t++) begin
            int te;
            set_enable(0);
            threshold = TW'(t); m_th = t;
            set_enable(1);
            te = eff_thr();
            for (int f = 0; f <= te; f++) run_frame(30 + t, 0, f[0], 0);
            check(frozen_err == 1'b1, "R5", $sformatf("trip at threshold %0d", t),
                  64'(frozen_err), 64'(1));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule